// File: doc/BRIEF.md
# Single-Precision to Unsigned Integer Truncating Converter

This block takes a 32-bit IEEE-754 single-precision operand and turns it into a 32-bit unsigned integer. It always rounds toward zero. Along with the integer it reports a raw two-bit exception vector, holding invalid and inexact, for a separate status unit to merge. It handles NaN, both infinities, negative operands, subnormals and magnitudes that do not fit in 32 bits. Any operand strictly below zero counts as invalid, even a small negative fraction that would truncate to zero.

An operand is presented with a one-cycle `validIn` strobe. One clock later `validOut` rises for one cycle. At that edge `resultOut` and `flagsOut` show the conversion. Both hold their values until the next accepted operand. Inside, a classifier sorts the operand and a control module turns the class into select and flag strobes. A datapath performs the shift and the fraction test and holds the output registers.

Top module: `f2u_trunc`

## Requirements
- R1: `validOut` is high exactly in the cycle after a cycle with `validIn` high. `resultOut` and `flagsOut` load only on an accepted operand and otherwise keep their values, whatever `opIn` does.
- R2: While `rstN` is low, `validOut`, `resultOut` and `flagsOut` are all zero.
- R3: A positive operand whose value is below 2^32 and at least 1 gives its integer part. If no fraction is discarded, `flagsOut` is 2'b00. Examples: 1.0 gives 1, 2^31 gives 0x80000000, and 0x4F7FFFFF gives 0xFFFFFF00.
- R4: A positive in-range operand that discards a nonzero fraction sets `flagsOut[0]`, the inexact bit, and only that bit. Example: 3.75 gives 3 with flags 2'b01.
- R5: Any NaN operand (exponent all ones, mantissa nonzero, either sign) gives result 0 and sets `flagsOut[1]`, the invalid bit, alone (flags 2'b10).
- R6: A negative operand with a nonzero magnitude gives result 0 and flags 2'b10. This covers -0.5, -1.5, a negative subnormal and -infinity.
- R7: +0 and -0 both give result 0 with flags 2'b00.
- R8: A positive operand of 2^32 or more, including +infinity, gives 0xFFFFFFFF with flags 2'b10.
- R9: A positive nonzero operand below 1.0, including every positive subnormal, gives 0 with flags 2'b01.
- R10: `flagsOut` is never 2'b11. Whenever invalid is raised, inexact is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operand strobe |
| opIn | input | 32 | Single-precision operand |
| validOut | output | 1 | Result strobe, one cycle after `validIn` |
| resultOut | output | 32 | Unsigned truncated integer |
| flagsOut | output | 2 | Bit 1 invalid, bit 0 inexact |

## Verification
Fraction detection and the invalid check can both be true in the same cycle. A negative operand with a fractional part, such as -1.5, -0.5 or a negative subnormal, drives both at once. The bench applies such operands and requires flags of exactly 2'b10, with the inexact bit suppressed. Back-to-back operands also check that one conversion's flags never leak into the next one.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

  localparam int FLAG_W   = 2;
  localparam int FLAG_INV = 1;
  localparam int FLAG_INX = 0;

  typedef struct packed {
    logic isNaN;
    logic isInf;
    logic isZero;
    logic isNeg;
    logic isBig;    // finite, magnitude >= 2^OUT_W
    logic isSmall;  // nonzero, magnitude < 1 (subnormals included)
  } opClass_t;

  typedef struct packed {
    logic load;
    logic selMax;
    logic selShift;
    logic raiseInv;
    logic raiseInxSmall;
    logic useFrac;
  } strobe_t;

endpackage

// File: rtl/f2u_classify.sv
module f2u_classify
  import f2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 32,
  localparam int IN_W = 1 + EXP_W + MAN_W,
  localparam int SH_W = $clog2(OUT_W),
  localparam int EW2  = EXP_W + 2
) (
  input  logic [IN_W-1:0] opIn,
  output opClass_t        opClass,
  output logic [SH_W-1:0] shiftAmt
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [EW2-1:0] BIAS_S = EW2'(BIAS);
  localparam logic signed [EW2-1:0] LIMIT_S = EW2'(OUT_W);

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [MAN_W-1:0]  manField;
  logic signed [EW2-1:0] expUnb;
  logic              expAllOnes;
  logic              expAllZero;
  logic              manZero;

  always_comb begin
    signBit    = opIn[IN_W-1];
    expField   = opIn[MAN_W +: EXP_W];
    manField   = opIn[MAN_W-1:0];
    expAllOnes = &expField;
    expAllZero = ~|expField;
    manZero    = ~|manField;
    expUnb     = signed'({2'b00, expField}) - BIAS_S;

    opClass.isNaN   = expAllOnes && !manZero;
    opClass.isInf   = expAllOnes && manZero;
    opClass.isZero  = expAllZero && manZero;
    opClass.isNeg   = signBit;
    opClass.isBig   = !expAllOnes && (expUnb >= LIMIT_S);
    opClass.isSmall = !(expAllZero && manZero) && expUnb[EW2-1];
    shiftAmt        = expUnb[SH_W-1:0];
  end

endmodule

// File: rtl/f2u_ctrl.sv
module f2u_ctrl
  import f2u_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     validIn,
  input  opClass_t opClass,
  output strobe_t  strobes,
  output logic     validOut
);

  // Priority: NaN, then nonzero negative, then zero, then overflow,
  // then sub-unity, then the normal shift path.
  always_comb begin
    strobes               = '0;
    strobes.load          = validIn;
    if (opClass.isNaN) begin
      strobes.raiseInv = 1'b1;
    end else if (opClass.isNeg && !opClass.isZero) begin
      strobes.raiseInv = 1'b1;
    end else if (opClass.isZero) begin
      strobes.raiseInv = 1'b0;
    end else if (opClass.isInf || opClass.isBig) begin
      strobes.selMax   = 1'b1;
      strobes.raiseInv = 1'b1;
    end else if (opClass.isSmall) begin
      strobes.raiseInxSmall = 1'b1;
    end else begin
      strobes.selShift = 1'b1;
      strobes.useFrac  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/f2u_datapath.sv
module f2u_datapath
  import f2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 32,
  localparam int IN_W  = 1 + EXP_W + MAN_W,
  localparam int SH_W  = $clog2(OUT_W),
  localparam int SIG_W = MAN_W + 1,
  localparam int WIDE  = OUT_W + SIG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_W-1:0]   opIn,
  input  logic [SH_W-1:0]   shiftAmt,
  input  strobe_t           strobes,
  output logic [OUT_W-1:0]  resultOut,
  output logic [FLAG_W-1:0] flagsOut
);

  logic [SIG_W-1:0] sig;
  logic [WIDE-1:0]  shifted;
  logic [OUT_W-1:0] intPart;
  logic             fracLost;
  logic [OUT_W-1:0] nextResult;
  logic [FLAG_W-1:0] nextFlags;
  logic             signUnused;
  logic [EXP_W-1:0] expUnused;

  always_comb begin
    signUnused = opIn[IN_W-1];
    expUnused  = opIn[MAN_W +: EXP_W];
    sig        = {1'b1, opIn[MAN_W-1:0]};
    shifted    = WIDE'(sig) << shiftAmt;
    intPart    = shifted[MAN_W +: OUT_W];
    fracLost   = |shifted[MAN_W-1:0];

    if (strobes.selMax)        nextResult = '1;
    else if (strobes.selShift) nextResult = intPart;
    else                       nextResult = '0;

    nextFlags           = '0;
    nextFlags[FLAG_INV] = strobes.raiseInv;
    nextFlags[FLAG_INX] = !strobes.raiseInv &&
                          (strobes.raiseInxSmall || (strobes.useFrac && fracLost));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      flagsOut  <= '0;
    end else if (strobes.load) begin
      resultOut <= nextResult;
      flagsOut  <= nextFlags;
    end
  end

endmodule

// File: rtl/f2u_trunc.sv
module f2u_trunc
  import f2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 32,
  localparam int IN_W = 1 + EXP_W + MAN_W,
  localparam int SH_W = $clog2(OUT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [IN_W-1:0]   opIn,
  output logic              validOut,
  output logic [OUT_W-1:0]  resultOut,
  output logic [FLAG_W-1:0] flagsOut
);

  opClass_t         opClass;
  strobe_t          strobes;
  logic [SH_W-1:0]  shiftAmt;

  f2u_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)) u_classify (
    .opIn     (opIn),
    .opClass  (opClass),
    .shiftAmt (shiftAmt)
  );

  f2u_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .opClass  (opClass),
    .strobes  (strobes),
    .validOut (validOut)
  );

  f2u_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .opIn      (opIn),
    .shiftAmt  (shiftAmt),
    .strobes   (strobes),
    .resultOut (resultOut),
    .flagsOut  (flagsOut)
  );

endmodule

// File: rtl/f2u_trunc_chk.sv
module f2u_trunc_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 32,
  localparam int IN_W = 1 + EXP_W + MAN_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic [IN_W-1:0]  opIn,
  input logic             validOut,
  input logic [OUT_W-1:0] resultOut,
  input logic [1:0]       flagsOut
);

  logic inNaN, inNegNz, inPosInf;
  always_comb begin
    inNaN    = (&opIn[MAN_W +: EXP_W]) && (|opIn[MAN_W-1:0]);
    inNegNz  = opIn[IN_W-1] && (|opIn[IN_W-2:0]);
    inPosInf = !opIn[IN_W-1] && (&opIn[MAN_W +: EXP_W]) && !(|opIn[MAN_W-1:0]);
  end

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(resultOut) && $stable(flagsOut)));
  p_nan_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && inNaN) |=> (resultOut == '0 && flagsOut == 2'b10));
  p_negative_r6: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && inNegNz) |=> (resultOut == '0 && flagsOut == 2'b10));
  p_pos_inf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && inPosInf) |=> (resultOut == '1 && flagsOut == 2'b10));
  p_no_both_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagsOut != 2'b11);

  always_comb begin
    if (!rstN) begin
      a_reset_r2: assert (validOut == 1'b0 && resultOut == '0 && flagsOut == '0);
    end
  end

endmodule

bind f2u_trunc f2u_trunc_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .opIn      (opIn),
  .validOut  (validOut),
  .resultOut (resultOut),
  .flagsOut  (flagsOut)
);

// File: tb/f2u_trunc_bench.sv
`timescale 1ns/1ps
module f2u_trunc_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [31:0] opIn = '0;
  logic        validOut;
  logic [31:0] resultOut;
  logic [1:0]  flagsOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  f2u_trunc u_f2u_trunc (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn),
    .validOut(validOut), .resultOut(resultOut), .flagsOut(flagsOut)
  );

  task automatic check(input string req, input logic [31:0] gotR, input logic [31:0] expR,
                       input logic [1:0] gotF, input logic [1:0] expF,
                       input logic gotV, input logic expV);
    checks++;
    if (gotR !== expR || gotF !== expF || gotV !== expV) begin
      failures++;
      $display("FAIL %s: result=%h flags=%b valid=%b expected result=%h flags=%b valid=%b",
               req, gotR, gotF, gotV, expR, expF, expV);
    end
  endtask

  // One operand, checked one cycle later at the falling edge.
  task automatic convert(input string req, input logic [31:0] op,
                         input logic [31:0] expR, input logic [1:0] expF);
    @(negedge clk);
    validIn = 1'b1;
    opIn    = op;
    @(negedge clk);
    validIn = 1'b0;
    check(req, resultOut, expR, flagsOut, expF, validOut, 1'b1);
  endtask

  task automatic test_reset();
    #1;
    check("R2 reset", resultOut, 32'h0, flagsOut, 2'b00, validOut, 1'b0);
    @(negedge clk);
    check("R2 reset held", resultOut, 32'h0, flagsOut, 2'b00, validOut, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic test_exact();
    convert("R3 one",      32'h3F80_0000, 32'd1,          2'b00);
    convert("R3 2^31",     32'h4F00_0000, 32'h8000_0000,  2'b00);
    convert("R3 largest",  32'h4F7F_FFFF, 32'hFFFF_FF00,  2'b00);
    convert("R3 2^23+1",   32'h4B00_0001, 32'd8388609,    2'b00);
    convert("R3 2^24-1",   32'h4B7F_FFFF, 32'd16777215,   2'b00);
  endtask

  task automatic test_inexact();
    convert("R4 3.75",        32'h4070_0000, 32'd3, 2'b01);
    convert("R4 near two",    32'h3FFF_FFFF, 32'd1, 2'b01);
  endtask

  task automatic test_nan();
    convert("R5 quiet NaN",   32'h7FC0_0000, 32'h0, 2'b10);
    convert("R5 neg sig NaN", 32'hFF80_0001, 32'h0, 2'b10);
  endtask

  task automatic test_negative();
    convert("R6 -0.5",        32'hBF00_0000, 32'h0, 2'b10);
    convert("R6 R10 -1.5",    32'hBFC0_0000, 32'h0, 2'b10);
    convert("R6 -inf",        32'hFF80_0000, 32'h0, 2'b10);
    convert("R6 R10 neg sub", 32'h8000_0001, 32'h0, 2'b10);
  endtask

  task automatic test_zero();
    convert("R7 +0", 32'h0000_0000, 32'h0, 2'b00);
    convert("R7 -0", 32'h8000_0000, 32'h0, 2'b00);
  endtask

  task automatic test_overflow();
    convert("R8 2^32", 32'h4F80_0000, 32'hFFFF_FFFF, 2'b10);
    convert("R8 +inf", 32'h7F80_0000, 32'hFFFF_FFFF, 2'b10);
    convert("R8 1e38", 32'h7E96_7699, 32'hFFFF_FFFF, 2'b10);
  endtask

  task automatic test_small();
    convert("R9 subnormal", 32'h0000_0001, 32'h0, 2'b01);
    convert("R9 0.5",       32'h3F00_0000, 32'h0, 2'b01);
  endtask

  task automatic test_hold();
    convert("R1 load", 32'h4120_0000, 32'd10, 2'b00);
    @(negedge clk);
    opIn = 32'h7FC0_0000;
    @(negedge clk);
    check("R1 hold", resultOut, 32'd10, flagsOut, 2'b00, validOut, 1'b0);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    validIn = 1'b1;
    opIn    = 32'hBFC0_0000;
    @(negedge clk);
    opIn    = 32'h4070_0000;
    check("R1 R10 first", resultOut, 32'h0, flagsOut, 2'b10, validOut, 1'b1);
    @(negedge clk);
    validIn = 1'b0;
    check("R1 R4 second", resultOut, 32'd3, flagsOut, 2'b01, validOut, 1'b1);
    @(negedge clk);
    check("R1 idle", resultOut, 32'd3, flagsOut, 2'b01, validOut, 1'b0);
  endtask

  initial begin
    test_reset();
    test_exact();
    test_inexact();
    test_nan();
    test_negative();
    test_zero();
    test_overflow();
    test_small();
    test_hold();
    test_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: result=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule